// File: doc/BRIEF.md
# I2S Sine Test-Tone Source

This block produces an endless stereo I2S stream that carries a mathematically exact sine tone. It is used to drive an audio DAC under test without any other signal source. One master clock does all the work. The bit clock sent to the DAC is that same clock, inverted. A free-running frame position counter produces the word-select line and marks when the next byte is due. Each 32-bit sample is sent as four bytes, most significant byte first. The bytes pass through an 8-bit parallel-load shift register, and a single flop then delays the serial data by one bit time. That delay gives the standard I2S alignment.

The tone comes from a one-period table that is computed when the design is elaborated. The table has 192 entries, so at a 192 kHz frame rate the tone is 1 kHz. A table entry is a signed value, `trunc(AMPLITUDE * sin(2*pi*k/192))`. The same entry is sent in the left slot and the right slot of a frame. The stream has no valid/ready handshake and cannot be back-pressured. The receiver must accept one bit on every rising edge of the bit clock. The only control is a synchronous, active-high reset, which restarts the stream from a known phase.

Top module: `i2s_tone_gen`

## Requirements
- R1: `sclk` is the inverse of `clk`. Every registered output therefore changes on a falling edge of `sclk`, half a period before the receiver samples on the rising edge.
- R2: Cycle 0 is the first bit clock after reset is released. `lrclk` is low in cycles 0 to 31 of each 64-cycle frame (left slot) and high in cycles 32 to 63 (right slot). It changes every 32 bit clocks and never at any other time.
- R3: Each slot carries a 32-bit word, sent most significant bit first. Bit 31 appears one bit clock after the `lrclk` edge that opens the slot. Bit 0 appears in the cycle in which `lrclk` next changes. So, for cycle t ≥ 1, `sdata` is bit `31 - ((t-1) mod 32)` of the word that belongs to cycle t-1.
- R4: Within a frame, the left and right slots carry the same table entry.
- R5: Frame f ≥ 1 carries table entry `(f-1) mod 192`. The index wraps from 191 to 0. Entry k is the two's-complement 32-bit value `trunc(AMPLITUDE * sin(2*pi*k/192))`.
- R6: After reset, `sdata` stays low through all of frame 0, which is cycles 0 to 64 including the delay stage. The first bit of entry 0 appears in cycle 65.
- R7: A reset applied in the middle of a stream clears the frame counter, the shift register, the delay flop and the table index. The stream then repeats exactly the sequence it produces after a reset at power-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, equal to the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| sclk | output | 1 | Bit clock to the receiver (inverted `clk`) |
| lrclk | output | 1 | Word select: low for left, high for right |
| sdata | output | 1 | Serial sample data, MSB first, delayed one bit |

## Verification
The bench builds the block with its default parameters: 32-bit slots, 8-bit bytes, a 192-entry table and an amplitude just below full scale. At these values one whole period of the tone takes only about 12,300 bit clocks. That is short enough for the bench to compare every bit of every slot over more than a full table period. The sweep includes the 191-to-0 index wrap, the silent first frame and a reset applied in the middle of a frame. Expected bits come from a sine function evaluated in the bench and from the bit-position arithmetic stated in R2 and R3.

// File: rtl/tone_pkg.sv
package tone_pkg;

  localparam real TONE_PI = 3.14159265358979323846;

  typedef enum logic {
    SLOT_LEFT  = 1'b0,
    SLOT_RIGHT = 1'b1
  } slot_e;

endpackage

// File: rtl/tone_frame_timer.sv
module tone_frame_timer #(
  parameter int SLOT_BITS = 32,
  parameter int BYTE_BITS = 8,
  localparam int FRAME_LEN = 2 * SLOT_BITS,
  localparam int POS_W     = $clog2(FRAME_LEN),
  localparam int SLOT_W    = $clog2(SLOT_BITS),
  localparam int BIT_W     = $clog2(BYTE_BITS),
  localparam int LANES     = SLOT_BITS / BYTE_BITS,
  localparam int LANE_W    = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  output tone_pkg::slot_e   slot_o,
  output logic              load_o,
  output logic [LANE_W-1:0] lane_o,
  output logic              live_o,
  output logic              advance_o
);

  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] pos_nxt;
  logic             live_q;
  logic             last_but_one;

  assign pos_nxt      = (pos_q == POS_W'(FRAME_LEN - 1)) ? '0 : pos_q + 1'b1;
  assign last_but_one = (pos_q == POS_W'(FRAME_LEN - 2));

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q  <= '0;
      live_q <= 1'b0;
    end else begin
      pos_q <= pos_nxt;
      if (last_but_one) live_q <= 1'b1;
    end
  end

  // A new byte enters the shifter on the edge that ends each byte period.
  assign load_o    = &pos_q[BIT_W-1:0];
  assign lane_o    = LANE_W'(pos_nxt[SLOT_W-1:BIT_W]);
  assign slot_o    = tone_pkg::slot_e'(pos_q[POS_W-1]);
  assign live_o    = live_q;
  assign advance_o = live_q && last_but_one;

endmodule

// File: rtl/tone_sine_rom.sv
module tone_sine_rom #(
  parameter int WORD_BITS = 32,
  parameter int DEPTH     = 192,
  parameter int AMPLITUDE = 2147483000,
  localparam int IDX_W    = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 advance_i,
  output logic [IDX_W-1:0]     idx_o,
  output logic [WORD_BITS-1:0] word_o
);

  localparam real AMP_R = real'(AMPLITUDE);

  logic [WORD_BITS-1:0] entry [DEPTH];
  logic [IDX_W-1:0]     idx_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    localparam real ANGLE = 2.0 * tone_pkg::TONE_PI * real'(g) / real'(DEPTH);
    assign entry[g] = WORD_BITS'($rtoi(AMP_R * $sin(ANGLE)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
    end else if (advance_i) begin
      idx_q <= (idx_q == IDX_W'(DEPTH - 1)) ? '0 : idx_q + 1'b1;
    end
  end

  assign idx_o  = idx_q;
  assign word_o = (int'(idx_q) < DEPTH) ? entry[idx_q] : '0;

endmodule

// File: rtl/tone_byte_serializer.sv
module tone_byte_serializer #(
  parameter int BYTE_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load_i,
  input  logic [BYTE_BITS-1:0] byte_i,
  output logic                 bit_o
);

  logic [BYTE_BITS-1:0] shift_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_q <= '0;
    end else if (load_i) begin
      shift_q <= byte_i;
    end else begin
      shift_q <= {shift_q[BYTE_BITS-2:0], 1'b0};
    end
  end

  assign bit_o = shift_q[BYTE_BITS-1];

endmodule

// File: rtl/tone_delay_stage.sv
module tone_delay_stage (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);

  always_ff @(posedge clk) begin
    if (rst) q_o <= 1'b0;
    else     q_o <= d_i;
  end

endmodule

// File: rtl/i2s_tone_gen.sv
module i2s_tone_gen #(
  parameter int SLOT_BITS = 32,
  parameter int BYTE_BITS = 8,
  parameter int DEPTH     = 192,
  parameter int AMPLITUDE = 2147483000,
  localparam int LANES    = SLOT_BITS / BYTE_BITS,
  localparam int LANE_W   = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int IDX_W    = $clog2(DEPTH)
) (
  input  logic clk,
  input  logic rst,
  output logic sclk,
  output logic lrclk,
  output logic sdata
);

  tone_pkg::slot_e      slot_w;
  logic                 load_w;
  logic [LANE_W-1:0]    lane_w;
  logic                 live_w;
  logic                 advance_w;
  logic [IDX_W-1:0]     phase_idx;
  logic [SLOT_BITS-1:0] sample_w;
  logic [BYTE_BITS-1:0] lane_bytes [LANES];
  logic [BYTE_BITS-1:0] load_byte;
  logic                 piso_bit;

  tone_frame_timer #(
    .SLOT_BITS(SLOT_BITS),
    .BYTE_BITS(BYTE_BITS)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .slot_o   (slot_w),
    .load_o   (load_w),
    .lane_o   (lane_w),
    .live_o   (live_w),
    .advance_o(advance_w)
  );

  tone_sine_rom #(
    .WORD_BITS(SLOT_BITS),
    .DEPTH    (DEPTH),
    .AMPLITUDE(AMPLITUDE)
  ) u_rom (
    .clk      (clk),
    .rst      (rst),
    .advance_i(advance_w),
    .idx_o    (phase_idx),
    .word_o   (sample_w)
  );

  // Lane 0 is the most significant byte of the word.
  for (genvar b = 0; b < LANES; b++) begin : g_lane
    assign lane_bytes[b] = sample_w[(LANES-1-b)*BYTE_BITS +: BYTE_BITS];
  end

  assign load_byte = live_w ? lane_bytes[lane_w] : '0;

  tone_byte_serializer #(
    .BYTE_BITS(BYTE_BITS)
  ) u_shift (
    .clk   (clk),
    .rst   (rst),
    .load_i(load_w),
    .byte_i(load_byte),
    .bit_o (piso_bit)
  );

  tone_delay_stage u_delay (
    .clk(clk),
    .rst(rst),
    .d_i(piso_bit),
    .q_o(sdata)
  );

  assign sclk  = ~clk;
  assign lrclk = (slot_w == tone_pkg::SLOT_RIGHT);

endmodule

// File: rtl/i2s_tone_gen_checker.sv
module i2s_tone_gen_checker #(
  parameter int SLOT_BITS = 32,
  parameter int DEPTH     = 192,
  localparam int IDX_W    = $clog2(DEPTH),
  localparam int CNT_W    = $clog2(2 * SLOT_BITS) + 1
) (
  input logic             clk,
  input logic             rst,
  input logic             lrclk,
  input logic             sdata,
  input logic             piso,
  input logic             live,
  input logic [IDX_W-1:0] idx
);

  logic             lr_prev;
  logic [CNT_W-1:0] since;

  always_ff @(posedge clk) begin
    if (rst) begin
      lr_prev <= 1'b0;
      since   <= '0;
    end else begin
      lr_prev <= lrclk;
      since   <= (lrclk != lr_prev) ? CNT_W'(1) : since + 1'b1;
    end
  end

  a_r2_lr_edge_spacing: assert property (@(posedge clk) disable iff (rst)
    (lrclk != lr_prev) |-> (since == CNT_W'(SLOT_BITS)));

  a_r2_lr_no_stall: assert property (@(posedge clk) disable iff (rst)
    since <= CNT_W'(SLOT_BITS));

  a_r3_one_bit_delay: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (sdata == $past(piso)));

  a_r4_index_moves_at_frame_end: assert property (@(posedge clk) disable iff (rst)
    (idx != $past(idx)) |-> (lrclk && since == CNT_W'(SLOT_BITS - 1)));

  a_r5_index_wraps: assert property (@(posedge clk) disable iff (rst)
    (idx != $past(idx) && $past(idx) == IDX_W'(DEPTH - 1)) |-> (idx == '0));

  a_r5_index_steps_by_one: assert property (@(posedge clk) disable iff (rst)
    (idx != $past(idx) && $past(idx) != IDX_W'(DEPTH - 1)) |-> (idx == $past(idx) + 1'b1));

  a_r6_quiet_first_frame: assert property (@(posedge clk) disable iff (rst)
    !$past(live) |-> !sdata);

endmodule

bind i2s_tone_gen i2s_tone_gen_checker #(
  .SLOT_BITS(SLOT_BITS),
  .DEPTH    (DEPTH)
) u_checker (
  .clk  (clk),
  .rst  (rst),
  .lrclk(lrclk),
  .sdata(sdata),
  .piso (piso_bit),
  .live (live_w),
  .idx  (phase_idx)
);

// File: tb/test_i2s_tone_gen.sv
module test_i2s_tone_gen;

  localparam int  AMP      = 2147483000;
  localparam int  TBL      = 192;
  localparam real MATH_PI  = 3.14159265358979323846;
  localparam int  WATCHDOG = 200000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk, lrclk, sdata;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  i2s_tone_gen #(
    .SLOT_BITS(32),
    .BYTE_BITS(8),
    .DEPTH    (TBL),
    .AMPLITUDE(AMP)
  ) i_i2s_tone_gen (
    .clk  (clk),
    .rst  (rst),
    .sclk (sclk),
    .lrclk(lrclk),
    .sdata(sdata)
  );

  function automatic logic [31:0] exp_word(int k);
    real a;
    a = 2.0 * MATH_PI * real'(k) / real'(TBL);
    return 32'($rtoi(real'(AMP) * $sin(a)));
  endfunction

  task automatic check_bit(string tag, int t, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s cycle %0d: got %b expected %b", tag, t, act, exp);
    end
  endtask

  // Called at a falling edge of clk, with cycle 0 being the reset state.
  task automatic run_span(int n, bit after_mid_reset);
    for (int t = 0; t < n; t++) begin
      logic exp_sd;
      string tag;
      int u, f, pos;
      check_bit("R2", t, lrclk, logic'((t / 32) % 2));
      if (t == 0) begin
        exp_sd = 1'b0;
        tag = after_mid_reset ? "R7" : "R6";
      end else begin
        u = t - 1;
        f = u / 64;
        pos = u % 32;
        if (f == 0) begin
          exp_sd = 1'b0;
          tag = "R6";
        end else begin
          exp_sd = exp_word((f - 1) % TBL)[31 - pos];
          if (after_mid_reset && t < 200) tag = "R7";
          else if (f > TBL)               tag = "R5";
          else if ((u % 64) >= 32)        tag = "R4";
          else                            tag = "R3";
        end
      end
      check_bit(tag, t, sdata, exp_sd);
      if (t < 64) check_bit("R1", t, sclk, 1'b1);
      @(posedge clk);
      #1;
      if (t < 64) check_bit("R1", t, sclk, 1'b0);
      @(negedge clk);
    end
  endtask

  task automatic apply_reset(int cycles);
    rst = 1'b1;
    repeat (cycles) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic report;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    apply_reset(3);
    // Power-up start, then reset in the middle of a right slot
    run_span(1000, 1'b0);
    repeat (13) @(negedge clk);
    apply_reset(2);
    // Covers more than a full table period, including the 191 -> 0 wrap
    run_span(64 * (TBL + 2) + 40, 1'b1);
    finished = 1;
    report();
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
      $finish;
    end
  end

endmodule